// File: doc/BRIEF.md
# Local Bus Read Sequencer

This block runs read cycles on a multiplexed address/data local bus for a general-purpose chip-select controller. A requester offers an address with a set of per-access timing options. The options are relaxed timing, extended read hold, an early-enable flag and a two-bit chip-select setup field. When the block is idle it accepts the access. It then drives the address with a one-cycle latch strobe and turns the shared bus around to input. Next it asserts chip select and output enable, waits a programmed number of cycles, and captures the returned data.

After every read the bus stays quiet for one mandatory turnaround cycle, during which the captured data is returned with a one-cycle valid pulse. Slow devices that release the bus late can ask for extra idle cycles, and the count depends on the hold and relaxed-timing options. The front end is a plain request/ready pair: ready is low from the acceptance edge until the last idle cycle has passed.

Top module: `lbr_read_seq`

## Requirements
- R1: After reset, ready is 1, chip select and output enable (both active low) are 1, and latch strobe, bus drive enable and data-valid are 0.
- R2: In the first cycle after acceptance, the latch strobe is 1 for exactly one cycle, the bus drive enable is 1, the request address is on the bus output, and chip select is still high. The bus drive enable is 0 in every later cycle of the access.
- R3: Chip select asserts in the cycle after the latch-strobe cycle when relaxed timing is 0, and two cycles after it when relaxed timing is 1.
- R4: Output enable asserts in the same cycle as chip select when the early flag is 1 and the setup field is 2'b10 or 2'b11. For every other combination (early flag 0, or setup field 2'b00 or 2'b01), it asserts one cycle after chip select.
- R5: Output enable never asserts while chip select is high or while the bus is driven, and it negates on the same clock edge as chip select.
- R6: Output enable stays low for W+1 cycles. W is the wait-state input (0 to 15), doubled when relaxed timing is 1.
- R7: Read data is sampled from the bus input in the last cycle in which output enable is low. It is presented with data-valid high for exactly one cycle, the cycle right after output enable negates.
- R8: The data-valid cycle is a turnaround cycle, with chip select and output enable both high. It always occurs, whatever the options.
- R9: After the turnaround cycle, the block adds extra idle cycles before ready returns: 4 with extended hold and relaxed timing, 1 with extended hold only, 1 with relaxed timing only, and 0 with neither.
- R10: Ready falls on the acceptance edge and stays low through the access and all of its idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request offered |
| req_addr | input | DW | Read address |
| opt_relax | input | 1 | Relaxed timing option |
| opt_ehold | input | 1 | Extended read hold option |
| opt_early | input | 1 | Early output-enable flag |
| opt_setup | input | 2 | Address-to-chip-select setup field |
| cfg_wait | input | WSW | Wait states between enable and capture |
| req_ready | output | 1 | Block can accept a request |
| bus_ale | output | 1 | Address latch strobe |
| bus_ad_out | output | DW | Address driven onto the shared bus |
| bus_ad_oe | output | 1 | Shared bus drive enable (1 = output) |
| bus_ad_in | input | DW | Data read from the shared bus |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Captured read data |

## Verification
The bench sweeps every combination that moves output enable relative to chip select, including setup field 2'b01 with the early flag set. A design that decodes only the early flag would assert output enable a cycle too soon there. Wait counts of 0 and 15, with and without doubling, catch an off-by-one or an undoubled count, which would show up as a data capture one cycle early or late or as a wrong output-enable width. All four hold combinations are run back to back. A missing turnaround cycle, or an idle count swapped between the options, would return ready at the wrong cycle. The bench model only returns valid data while output enable is low and the bus is not driven, so a capture taken on the wrong cycle reads back the wrong value.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETUP,
    ST_CSONLY,
    ST_ACTIVE,
    ST_TURN,
    ST_HOLD
  } lbr_state_e;

  typedef struct packed {
    logic       relax;
    logic       ehold;
    logic       early;
    logic [1:0] setup;
  } lbr_opt_t;

endpackage

// File: rtl/lbr_timing_calc.sv
module lbr_timing_calc
  import lbr_pkg::*;
#(
  parameter int WSW        = 4,
  parameter int HOLD_BOTH  = 4,
  parameter int HOLD_EXT   = 1,
  parameter int HOLD_RELAX = 1
) (
  input  lbr_opt_t       opt,
  input  logic [WSW-1:0] wait_states,
  output logic           early_oe,
  output logic [WSW:0]   wait_cnt,
  output logic [WSW:0]   hold_cnt
);
  localparam int CW = WSW + 1;

  // enable coincides with select only for the early flag with a long setup code
  assign early_oe = opt.early && opt.setup[1];

  // relaxed timing doubles the wait window
  assign wait_cnt = opt.relax ? {wait_states, 1'b0} : {1'b0, wait_states};

  always_comb begin
    unique case ({opt.ehold, opt.relax})
      2'b11:   hold_cnt = CW'(HOLD_BOTH);
      2'b10:   hold_cnt = CW'(HOLD_EXT);
      2'b01:   hold_cnt = CW'(HOLD_RELAX);
      default: hold_cnt = '0;
    endcase
  end
endmodule

// File: rtl/lbr_read_fsm.sv
module lbr_read_fsm
  import lbr_pkg::*;
#(
  parameter int WSW = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_fire,
  input  logic         relax,
  input  logic         early_oe,
  input  logic [WSW:0] wait_cnt,
  input  logic [WSW:0] hold_cnt,
  output lbr_state_e   state_d,
  output logic         cap_en
);
  localparam int CW = WSW + 1;

  lbr_state_e    state_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:   if (req_fire) state_d = ST_ADDR;
      ST_ADDR: begin
        if (relax) state_d = ST_SETUP;
        else if (early_oe) begin
          state_d = ST_ACTIVE;
          cnt_d   = wait_cnt;
        end else state_d = ST_CSONLY;
      end
      ST_SETUP: begin
        if (early_oe) begin
          state_d = ST_ACTIVE;
          cnt_d   = wait_cnt;
        end else state_d = ST_CSONLY;
      end
      ST_CSONLY: begin
        state_d = ST_ACTIVE;
        cnt_d   = wait_cnt;
      end
      ST_ACTIVE: begin
        if (cnt_q == '0) state_d = ST_TURN;
        else cnt_d = cnt_q - 1'b1;
      end
      ST_TURN: begin
        if (hold_cnt == '0) state_d = ST_IDLE;
        else begin
          state_d = ST_HOLD;
          cnt_d   = hold_cnt - 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cap_en = (state_q == ST_ACTIVE) && (cnt_q == '0);

  // R8: a capture is always followed by the turnaround cycle
  assert_turn_after_capture_R8: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> (state_q == ST_TURN));

  // R10: no new access starts from anywhere but idle
  assert_addr_from_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR) |-> ($past(state_q) == ST_IDLE));
endmodule

// File: rtl/lbr_data_capture.sv
module lbr_data_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [DW-1:0] bus_ad_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= bus_ad_in;
    end
  end

  // R7: data-valid is a single-cycle pulse
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/lbr_pin_driver.sv
module lbr_pin_driver
  import lbr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  lbr_state_e    state_d,
  input  logic          req_fire,
  input  logic [DW-1:0] req_addr,
  input  logic          rd_valid,
  output logic          bus_ale,
  output logic          bus_ad_oe,
  output logic [DW-1:0] bus_ad_out,
  output logic          bus_cs_n,
  output logic          bus_oe_n,
  output logic          req_ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ale    <= 1'b0;
      bus_ad_oe  <= 1'b0;
      bus_ad_out <= '0;
      bus_cs_n   <= 1'b1;
      bus_oe_n   <= 1'b1;
      req_ready  <= 1'b1;
    end else begin
      bus_ale   <= (state_d == ST_ADDR);
      bus_ad_oe <= (state_d == ST_ADDR);
      bus_cs_n  <= !((state_d == ST_CSONLY) || (state_d == ST_ACTIVE));
      bus_oe_n  <= (state_d != ST_ACTIVE);
      req_ready <= (state_d == ST_IDLE);
      if (req_fire) bus_ad_out <= req_addr;
    end
  end

  // R2: the latch strobe lasts one cycle, with the bus driven and select idle
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> !bus_ale);
  assert_ale_drive_R2: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> (bus_ad_oe && bus_cs_n));

  // R5: enable only inside select and with the bus released
  assert_oe_inside_cs_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> (!bus_cs_n && !bus_ad_oe));
  assert_oe_cs_negate_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe_n) |-> $rose(bus_cs_n));

  // R8: valid data comes back in a quiet bus cycle
  assert_turn_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (bus_cs_n && bus_oe_n && !bus_ad_oe));

  // R10: never ready while select is active
  assert_busy_in_access_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_cs_n |-> !req_ready);
endmodule

// File: rtl/lbr_read_seq.sv
module lbr_read_seq
  import lbr_pkg::*;
#(
  parameter int DW         = 16,
  parameter int WSW        = 4,
  parameter int HOLD_BOTH  = 4,
  parameter int HOLD_EXT   = 1,
  parameter int HOLD_RELAX = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [DW-1:0]  req_addr,
  input  logic           opt_relax,
  input  logic           opt_ehold,
  input  logic           opt_early,
  input  logic [1:0]     opt_setup,
  input  logic [WSW-1:0] cfg_wait,
  output logic           req_ready,
  output logic           bus_ale,
  output logic [DW-1:0]  bus_ad_out,
  output logic           bus_ad_oe,
  input  logic [DW-1:0]  bus_ad_in,
  output logic           bus_cs_n,
  output logic           bus_oe_n,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data
);
  localparam int CW = WSW + 1;

  lbr_opt_t       opt_q;
  logic [WSW-1:0] wait_q;
  logic           req_fire;
  logic           early_oe;
  logic [CW-1:0]  wait_cnt, hold_cnt;
  lbr_state_e     state_d;
  logic           cap_en;

  assign req_fire = req_valid && req_ready;

  // options are held for the whole access
  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q  <= '0;
      wait_q <= '0;
    end else if (req_fire) begin
      opt_q  <= '{relax: opt_relax, ehold: opt_ehold, early: opt_early, setup: opt_setup};
      wait_q <= cfg_wait;
    end
  end

  lbr_timing_calc #(
    .WSW(WSW), .HOLD_BOTH(HOLD_BOTH), .HOLD_EXT(HOLD_EXT), .HOLD_RELAX(HOLD_RELAX)
  ) u_calc (
    .opt(opt_q), .wait_states(wait_q),
    .early_oe(early_oe), .wait_cnt(wait_cnt), .hold_cnt(hold_cnt)
  );

  lbr_read_fsm #(.WSW(WSW)) u_fsm (
    .clk(clk), .rst(rst), .req_fire(req_fire), .relax(opt_q.relax),
    .early_oe(early_oe), .wait_cnt(wait_cnt), .hold_cnt(hold_cnt),
    .state_d(state_d), .cap_en(cap_en)
  );

  lbr_data_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .bus_ad_in(bus_ad_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  lbr_pin_driver #(.DW(DW)) u_pins (
    .clk(clk), .rst(rst), .state_d(state_d), .req_fire(req_fire),
    .req_addr(req_addr), .rd_valid(rd_valid),
    .bus_ale(bus_ale), .bus_ad_oe(bus_ad_oe), .bus_ad_out(bus_ad_out),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .req_ready(req_ready)
  );
endmodule

// File: tb/lbr_read_seq_bench.sv
module lbr_read_seq_bench;
  localparam int DW  = 16;
  localparam int WSW = 4;
  localparam logic [DW-1:0] PAT = 16'h5A3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [DW-1:0] req_addr = '0;
  logic opt_relax = 1'b0, opt_ehold = 1'b0, opt_early = 1'b0;
  logic [1:0] opt_setup = 2'b00;
  logic [WSW-1:0] cfg_wait = '0;
  logic req_ready, bus_ale, bus_ad_oe, bus_cs_n, bus_oe_n, rd_valid;
  logic [DW-1:0] bus_ad_out, bus_ad_in, rd_data;
  logic [DW-1:0] ext_latch = '0;

  always #5 clk = ~clk;

  lbr_read_seq u_lbr_read_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .opt_relax(opt_relax), .opt_ehold(opt_ehold), .opt_early(opt_early),
    .opt_setup(opt_setup), .cfg_wait(cfg_wait), .req_ready(req_ready),
    .bus_ale(bus_ale), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // external address latch and memory model
  always @(posedge clk) if (bus_ale && bus_ad_oe) ext_latch <= bus_ad_out;
  assign bus_ad_in = (!bus_oe_n && !bus_ad_oe) ? (ext_latch ^ PAT) : 16'h0000;

  typedef struct {
    logic [DW-1:0] addr;
    bit relax; bit early; int weff; int hold;
  } exp_t;
  exp_t sbq[$];

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int expv, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic issue(logic [DW-1:0] a, bit rl, bit eh, bit ea, logic [1:0] su, int w);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a; opt_relax = rl; opt_ehold = eh; opt_early = ea; opt_setup = su;
    cfg_wait = WSW'(w);
    e.addr  = a;
    e.relax = rl;
    e.early = ea && su[1];
    e.weff  = rl ? 2 * w : w;
    e.hold  = eh ? (rl ? 4 : 1) : (rl ? 1 : 0);
    sbq.push_back(e);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", int'(req_ready), 0, "ready after accept");
  endtask

  // monitor
  int t_ale, t_cs, t_oe, t_v;
  logic p_cs = 1'b1, p_oe = 1'b1, p_rdy = 1'b1, p_v = 1'b0;
  logic [DW-1:0] got_data;
  bit bad_oe;

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (p_v) chk(rd_valid == 1'b0, "R7", int'(rd_valid), 0, "valid pulse width");
        if (bus_ale) begin
          t_ale = cyc; bad_oe = 0;
          chk(sbq.size() > 0 && bus_ad_out == sbq[0].addr && bus_ad_oe && bus_cs_n,
              "R2", int'(bus_ad_out), (sbq.size() > 0) ? int'(sbq[0].addr) : -1, "address phase");
        end
        if (!bus_ale && bus_ad_oe) bad_oe = 1;
        if (!bus_oe_n && (bus_cs_n || bus_ad_oe)) bad_oe = 1;
        if (p_cs && !bus_cs_n) t_cs = cyc;
        if (p_oe && !bus_oe_n) t_oe = cyc;
        if (!p_oe && bus_oe_n)
          chk(bus_cs_n && !p_cs, "R5", int'(bus_cs_n), 1, "select negates with enable");
        if (rd_valid) begin
          t_v = cyc; got_data = rd_data;
          chk(bus_cs_n && bus_oe_n, "R8", int'({bus_cs_n, bus_oe_n}), 3, "quiet turnaround");
        end
        if (!p_rdy && req_ready) begin
          exp_t e;
          if (sbq.size() == 0) chk(0, "R10", 0, 1, "ready rise without access");
          else begin
            e = sbq.pop_front();
            chk(!bad_oe, "R5", int'(bad_oe), 0, "enable overlap or late drive");
            chk(t_cs - t_ale == 1 + int'(e.relax), "R3", t_cs - t_ale, 1 + int'(e.relax), "select delay");
            chk(t_oe - t_cs == (e.early ? 0 : 1), "R4", t_oe - t_cs, e.early ? 0 : 1, "enable delay");
            chk(t_v - t_oe == e.weff + 1, "R6", t_v - t_oe, e.weff + 1, "enable width");
            chk(got_data == (e.addr ^ PAT), "R7", int'(got_data), int'(e.addr ^ PAT), "captured data");
            chk(cyc - t_v == 1 + e.hold, "R9", cyc - t_v, 1 + e.hold, "idle before ready");
          end
        end
        p_cs = bus_cs_n; p_oe = bus_oe_n; p_rdy = req_ready; p_v = rd_valid;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready && bus_cs_n && bus_oe_n && !bus_ale && !bus_ad_oe && !rd_valid,
        "R1", int'({req_ready, bus_cs_n, bus_oe_n, bus_ale, bus_ad_oe, rd_valid}), 56, "reset state");
    issue(16'h1234, 0, 0, 0, 2'b00, 0);   // fastest read
    issue(16'h0F0F, 0, 0, 1, 2'b10, 0);   // early enable
    issue(16'hA001, 0, 0, 1, 2'b11, 3);
    issue(16'h7777, 0, 0, 1, 2'b01, 2);   // early flag but short setup
    issue(16'hBEEF, 0, 0, 0, 2'b11, 1);   // long setup without flag
    issue(16'h0102, 1, 0, 0, 2'b00, 2);   // relaxed
    issue(16'hC3C3, 1, 1, 1, 2'b10, 1);   // relaxed + hold, early
    issue(16'h5555, 0, 1, 0, 2'b00, 15);  // hold, max wait
    issue(16'hFFFF, 1, 1, 0, 2'b11, 15);  // doubled max wait
    issue(16'h0000, 1, 0, 1, 2'b11, 0);
    while (sbq.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule